// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial core of an SPI master. It takes words from an output FIFO and sends them most significant bit first on `mosi`. It collects the bits returned on `miso` into words and hands each one to an input FIFO. It also produces the serial clock and a chip-select. A transfer starts with a one-cycle `start` pulse that carries a word count. The engine then moves exactly that many words and signals the end with a one-cycle `done` pulse.

Several settings shape each transfer, all latched at `start`:

- The word length is coded as length minus one.
- The sampling phase is set by an input-first option. When set, a bit is sampled on the leading clock edge; when clear, on the trailing edge.
- A loopback option feeds the transmitted bits back into the receive path.
- A left-align option selects which part of the output word is sent.

The clock idle level and the chip-select polarity and force are static settings. If the output FIFO runs dry in the middle of a transfer, the engine does not send stale data. It holds the serial clock at its idle level and raises a sticky underrun flag.

Top module: `spi_shift_engine`

## Requirements
- R1: Each word has `cfg_len_m1`+1 bits (field value 0 gives 1 bit, 31 gives 32 bits), and each received word appears on `rx_data` right-aligned with all higher bits zero.
- R2: Bits are sent most significant first. With `cfg_align`=1 the bits sent are `tx_data[N-1:0]`, starting with bit N-1. With `cfg_align`=0 they are the top N bits, starting with bit DATA_W-1.
- R3: `sclk` equals `cfg_idle_high` whenever no bit is being shifted. Within a word, consecutive sampling edges are 2*DIV_HALF clock cycles apart.
- R4: With `cfg_input_first`=1, `miso` is sampled on the leading `sclk` edge (the edge away from the idle level) and `mosi` changes on the trailing edge. With it clear, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R5: With `cfg_loopback`=1, the received bits are the transmitted `mosi` bits and `miso` is ignored.
- R6: A start with `word_count`=K>0 pops exactly K words and pushes exactly K words. It then pulses `done` once, in the cycle where `busy` falls. A start with `word_count`=0 does nothing.
- R7: `cs` sits at its active level (`cfg_cs_active_high`) for the whole transfer and at the opposite level when idle. The exception is `cfg_force_cs`=1, which holds `cs` active while idle too.
- R8: When a word is needed and `tx_valid` is low, the engine stalls. No `sclk` edges occur, `sclk` stays idle and `clk_underrun` is set. Shifting resumes when data arrives, and the flag clears at the next accepted start.
- R9: `tx_pop` is asserted only in a cycle where `tx_valid` is high.
- R10: A `start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| word_count | input | CNT_W | Number of words in the transfer |
| cfg_len_m1 | input | LEN_W | Word length minus one |
| cfg_idle_high | input | 1 | Serial clock idle level |
| cfg_input_first | input | 1 | Sample on the leading edge when set |
| cfg_loopback | input | 1 | Route transmitted bits back to the receiver |
| cfg_align | input | 1 | Send the low N bits of the word when set |
| cfg_cs_active_high | input | 1 | Active level of chip-select |
| cfg_force_cs | input | 1 | Hold chip-select active while idle |
| tx_valid | input | 1 | Output FIFO holds a word |
| tx_data | input | DATA_W | Head word of the output FIFO |
| tx_pop | output | 1 | Take the head word |
| rx_push | output | 1 | Received word valid (one-cycle pulse) |
| rx_data | output | DATA_W | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip-select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished (one-cycle pulse) |
| clk_underrun | output | 1 | Sticky stall flag |

## Verification
The bench acts as a serial device. It captures `mosi` on each sampling edge and changes `miso` to a fresh random bit on each driving edge. This exposes a wrong sampling phase, because a bit sampled on the wrong edge no longer matches the value that was present. Random transfers sweep word length from 1 to 32 bits across all combinations of idle level, phase, alignment and loopback. Within that sweep, alignment errors show up in the `mosi` stream and loopback errors show up in the received words. Directed cases cover:
- a starved output FIFO, which must stall the clock;
- a start with a zero count;
- a start arriving mid-transfer;
- forced chip-select.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_FETCH = 2'd1,
      ENG_SHIFT = 2'd2
   } eng_state_t;
endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == LAST);

   AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST); // R3
endmodule

// File: rtl/spi_eng_txsh.sv
module spi_eng_txsh #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic              align,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic [DATA_W-1:0] din,
   output logic              msb
);
   logic [DATA_W-1:0] sh;
   logic [LEN_W-1:0]  lshift;

   assign lshift = LEN_W'(DATA_W - 1) - len_m1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= align ? (din << lshift) : din;
      else if (shift) sh <= {sh[DATA_W-2:0], 1'b0};
   end

   assign msb = sh[DATA_W-1];

   AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift)); // R2
endmodule

// File: rtl/spi_eng_rxsh.sv
module spi_eng_rxsh #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  logic              bit_in,
   input  logic              finish,
   input  logic [LEN_W-1:0]  len_m1,
   output logic              push,
   output logic [DATA_W-1:0] data
);
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] keep;

   assign keep = ~({DATA_W{1'b1}} << ({1'b0, len_m1} + 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh <= '0;
      else if (clear)  sh <= '0;
      else if (sample) sh <= {sh[DATA_W-2:0], bit_in};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         push <= 1'b0;
         data <= '0;
      end else begin
         push <= finish;
         if (finish) data <= sh & keep;
      end
   end

   AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push); // R6
   AST_NO_SAMPLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample && finish)); // R4
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_eng_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 16,
   parameter int DIV_HALF = 2,
   localparam int LEN_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  word_count,
   input  logic [LEN_W-1:0]  cfg_len_m1,
   input  logic              cfg_idle_high,
   input  logic              cfg_input_first,
   input  logic              cfg_loopback,
   input  logic              cfg_align,
   input  logic              cfg_cs_active_high,
   input  logic              cfg_force_cs,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_data,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              cs,
   output logic              busy,
   output logic              done,
   output logic              clk_underrun
);
   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   eng_state_t       state;
   logic [CNT_W-1:0] words_left;
   logic [LEN_W-1:0] bits_left;
   logic [LEN_W-1:0] len_q;
   logic             phase;
   logic             first_q, loop_q, align_q;
   logic             tick, shifting, last_bit;
   logic             do_sample, do_shift, do_finish, tx_msb, rx_bit;

   assign shifting  = (state == ENG_SHIFT);
   assign last_bit  = (bits_left == '0);
   assign do_sample = shifting && tick && !phase;
   assign do_shift  = shifting && tick && phase && !last_bit;
   assign do_finish = shifting && tick && phase && last_bit;
   assign tx_pop    = (state == ENG_FETCH) && tx_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ENG_IDLE;
         words_left   <= '0;
         bits_left    <= '0;
         len_q        <= '0;
         phase        <= 1'b0;
         first_q      <= 1'b0;
         loop_q       <= 1'b0;
         align_q      <= 1'b0;
         done         <= 1'b0;
         clk_underrun <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ENG_IDLE: begin
               if (start && word_count != '0) begin
                  words_left   <= word_count;
                  len_q        <= cfg_len_m1;
                  first_q      <= cfg_input_first;
                  loop_q       <= cfg_loopback;
                  align_q      <= cfg_align;
                  clk_underrun <= 1'b0;
                  state        <= ENG_FETCH;
               end
            end
            ENG_FETCH: begin
               if (tx_valid) begin
                  bits_left <= len_q;
                  phase     <= 1'b0;
                  state     <= ENG_SHIFT;
               end else begin
                  clk_underrun <= 1'b1;
               end
            end
            ENG_SHIFT: begin
               if (tick) begin
                  if (!phase) begin
                     phase <= 1'b1;
                  end else if (!last_bit) begin
                     bits_left <= bits_left - 1'b1;
                     phase     <= 1'b0;
                  end else begin
                     words_left <= words_left - 1'b1;
                     if (words_left == CNT_W'(1)) begin
                        state <= ENG_IDLE;
                        done  <= 1'b1;
                     end else begin
                        state <= ENG_FETCH;
                     end
                  end
               end
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   spi_eng_tick #(.DIV_HALF(DIV_HALF)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (shifting),
      .tick (tick)
   );

   spi_eng_txsh #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_txsh (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tx_pop),
      .shift (do_shift),
      .align (align_q),
      .len_m1(len_q),
      .din   (tx_data),
      .msb   (tx_msb)
   );

   assign mosi   = shifting ? tx_msb : 1'b0;
   assign rx_bit = loop_q ? mosi : miso;

   spi_eng_rxsh #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rxsh (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tx_pop),
      .sample(do_sample),
      .bit_in(rx_bit),
      .finish(do_finish),
      .len_m1(len_q),
      .push  (rx_push),
      .data  (rx_data)
   );

   // Phase 0 is the idle half when sampling leads, the active half otherwise.
   assign sclk = shifting ? (cfg_idle_high ^ (first_q ? phase : ~phase)) : cfg_idle_high;
   assign busy = (state != ENG_IDLE);
   assign cs   = (busy || cfg_force_cs) ? cfg_cs_active_high : ~cfg_cs_active_high;

   AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> tx_valid); // R9
   AST_SCLK_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sclk == cfg_idle_high); // R3
   AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cs == cfg_cs_active_high); // R7
   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R6
   AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !shifting && !tx_valid) |=> $stable(sclk)); // R8
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> busy); // R10
endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;
   localparam int CLK_P = 10;
   localparam int DIVH  = 2;
   localparam int DW    = 32;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [15:0] word_count = '0;
   logic [4:0]  cfg_len_m1 = 5'd7;
   logic cfg_idle_high = 1'b0, cfg_input_first = 1'b1, cfg_loopback = 1'b0;
   logic cfg_align = 1'b1, cfg_cs_active_high = 1'b0, cfg_force_cs = 1'b0;
   logic tx_valid, tx_pop, rx_push, sclk, mosi, cs, busy, done, clk_underrun;
   logic [DW-1:0] tx_data, rx_data;
   logic miso_r = 1'b0;

   logic [DW-1:0] txq [0:511];
   logic [DW-1:0] rxq [0:63];
   bit   mosi_bits [0:1023];
   bit   miso_bits [0:1023];
   int rd = 0, wr = 0, nrx = 0, nbits = 0, per_bad = 0, cs_bad = 0;
   int checks = 0, fails = 0, cyc = 0, last_cyc = 0, cur_n = 8;
   bit mon_en = 1'b0, mon_lb = 1'b0, prev_sclk = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   assign tx_valid = (rd < wr);
   assign tx_data  = txq[rd[8:0]];

   spi_shift_engine #(.DATA_W(DW), .CNT_W(16), .DIV_HALF(DIVH)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
      .cfg_len_m1(cfg_len_m1), .cfg_idle_high(cfg_idle_high),
      .cfg_input_first(cfg_input_first), .cfg_loopback(cfg_loopback),
      .cfg_align(cfg_align), .cfg_cs_active_high(cfg_cs_active_high),
      .cfg_force_cs(cfg_force_cs), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk),
      .mosi(mosi), .miso(miso_r), .cs(cs), .busy(busy), .done(done),
      .clk_underrun(clk_underrun));

   always @(posedge clk) if (tx_pop) rd <= rd + 1;

   always @(negedge clk) begin
      cyc++;
      if (rx_push && nrx < 64) begin rxq[nrx] = rx_data; nrx++; end
      if (mon_en && sclk != prev_sclk) begin
         if ((prev_sclk == cfg_idle_high) == cfg_input_first) begin
            mosi_bits[nbits] = mosi;
            miso_bits[nbits] = mon_lb ? mosi : miso_r;
            if ((nbits % cur_n) != 0 && (cyc - last_cyc) != 2*DIVH) per_bad++;
            if (cs != cfg_cs_active_high) cs_bad++;
            last_cyc = cyc;
            if (nbits < 1023) nbits++;
         end else begin
            miso_r = 1'($urandom % 2);
         end
      end
      prev_sclk = sclk;
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   always @(posedge clk) if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R6 watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #(CLK_P/4); end
   endtask

   task automatic wait_done();
      for (int i = 0; i < 20000; i++) begin
         step(1);
         if (done) return;
      end
   endtask

   function automatic logic [DW-1:0] sent_bits(logic [DW-1:0] w, int n, bit al);
      logic [63:0] m = (64'd1 << n) - 1;
      return al ? DW'(w & m[DW-1:0]) : (w >> (DW - n));
   endfunction

   function automatic logic [DW-1:0] gather(bit from_miso, int k, int n);
      logic [DW-1:0] v = '0;
      for (int i = 0; i < n; i++)
         v[n-1-i] = from_miso ? miso_bits[k*n+i] : mosi_bits[k*n+i];
      return v;
   endfunction

   task automatic begin_xfer(int nm1, bit idle, bit inf, bit lb, bit al, bit pol);
      cfg_len_m1 = 5'(nm1); cfg_idle_high = idle; cfg_input_first = inf;
      cfg_loopback = lb; cfg_align = al; cfg_cs_active_high = pol;
      cur_n = nm1 + 1; mon_lb = lb;
      step(2);
      nbits = 0; nrx = 0; per_bad = 0; cs_bad = 0; mon_en = 1'b1;
   endtask

   task automatic check_words(int base, int nw, bit lb, bit al);
      for (int k = 0; k < nw; k++) begin
         chk(rxq[k] == gather(1'b1, k, cur_n), lb ? "R5" : "R4", "rx word",
             rxq[k], gather(1'b1, k, cur_n));
         chk(gather(1'b0, k, cur_n) == sent_bits(txq[base+k], cur_n, al), "R2",
             "mosi word", gather(1'b0, k, cur_n), sent_bits(txq[base+k], cur_n, al));
      end
   endtask

   task automatic run_xfer(int nm1, int nw, bit idle, bit inf, bit lb, bit al, bit pol);
      int base;
      begin_xfer(nm1, idle, inf, lb, al, pol);
      base = wr;
      for (int k = 0; k < nw; k++) begin txq[wr[8:0]] = $urandom; wr++; end
      start = 1'b1; word_count = 16'(nw);
      step(1);
      start = 1'b0;
      wait_done();
      step(3);
      mon_en = 1'b0;
      chk(nrx == nw, "R6", "word count", nrx, nw);
      chk(nbits == nw * cur_n, "R1", "bit count", nbits, nw * cur_n);
      check_words(base, nw, lb, al);
      chk(per_bad == 0, "R3", "bit period errors", per_bad, 0);
      chk(cs_bad == 0 && cs == ~pol, "R7", "cs framing", {cs_bad, cs}, {32'd0, ~pol});
      chk(sclk == idle, "R3", "sclk idle", sclk, idle);
      chk(clk_underrun == 1'b0 && rd == wr, "R8", "underrun/pop", {clk_underrun, rd}, wr);
   endtask

   initial begin
      void'($urandom(32'd1234));
      step(3);
      chk(sclk == 1'b0 && cs == 1'b1 && !busy && !rx_push && !done, "R7",
          "reset state", {sclk, cs, busy, rx_push, done}, 5'b01000);
      rst_n = 1'b1;
      step(2);

      // R6: zero count does nothing
      start = 1'b1; word_count = '0;
      step(1); start = 1'b0; step(1);
      chk(!busy && rd == wr, "R6", "zero count", busy, 0);

      // directed corners: 1-bit and 32-bit words, each phase and idle level
      run_xfer(7, 2, 0, 1, 0, 1, 0);
      run_xfer(7, 2, 1, 0, 0, 0, 1);
      run_xfer(0, 3, 0, 0, 0, 1, 0);
      run_xfer(31, 2, 1, 1, 1, 0, 0);
      run_xfer(31, 1, 0, 0, 0, 1, 1);

      // R7: forced chip-select while idle
      cfg_cs_active_high = 1'b0; cfg_force_cs = 1'b1; step(1);
      chk(cs == 1'b0, "R7", "forced cs", cs, 0);
      cfg_force_cs = 1'b0; step(1);
      chk(cs == 1'b1, "R7", "released cs", cs, 1);

      // R8: output FIFO starved after one word
      begin
         int base;
         begin_xfer(7, 1, 1, 0, 1, 0);
         base = wr;
         txq[wr[8:0]] = 32'h0000_00A5; wr++;
         start = 1'b1; word_count = 16'd3; step(1); start = 1'b0;
         step(60);
         chk(clk_underrun == 1'b1, "R8", "underrun flag", clk_underrun, 1);
         chk(sclk == 1'b1 && busy, "R8", "stalled sclk", {sclk, busy}, 2'b11);
         chk(nbits == 8, "R8", "bits before stall", nbits, 8);
         for (int k = 0; k < 2; k++) begin txq[wr[8:0]] = $urandom; wr++; end
         wait_done(); step(3); mon_en = 1'b0;
         chk(nrx == 3, "R8", "words after resume", nrx, 3);
         check_words(base, 3, 0, 1);
      end

      // R10: start while busy is ignored
      begin
         int base;
         begin_xfer(15, 0, 0, 0, 1, 0);
         base = wr;
         for (int k = 0; k < 2; k++) begin txq[wr[8:0]] = $urandom; wr++; end
         start = 1'b1; word_count = 16'd2; step(1); start = 1'b0;
         step(10);
         start = 1'b1; word_count = 16'd5; step(1); start = 1'b0;
         wait_done(); step(3); mon_en = 1'b0;
         chk(nrx == 2 && !busy && !clk_underrun, "R10", "restart ignored",
             {nrx, busy, clk_underrun}, {32'd2, 2'b00});
         check_words(base, 2, 0, 1);
      end

      // random sweep
      for (int t = 0; t < 24; t++)
         run_xfer($urandom % 32, 1 + ($urandom % 4), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom));

      summary();
      $finish;
   end
endmodule